// File: doc/BRIEF.md
# Sliding-Sum Wide Smoothing Filter

This block smooths one line of pixels that crosses a block edge in a video deblocking path. A line holds sixteen samples, eight on each side of the edge. A medium smoother replaces the three samples nearest the edge on each side. A wide smoother replaces the seven nearest samples on each side. The outermost sample on each side is never changed. The mask decision that picks which smoother to apply is made upstream, and the narrow four-tap adjustment is done downstream. This block only does the smoothing and the per-line selection.

Each output tap is the rounded, right-shifted sum of a symmetric window centred on the tap. The centre sample counts twice, and window positions that fall past the edge of the available samples repeat the outermost sample. The hardware keeps one running sum per smoother. To move from one tap to the next, it subtracts the tap's original sample and the sample leaving the window, then adds the next tap's original sample and the sample entering the window. All subtractions use the unfiltered samples.

The block accepts one line every cycle. Each result appears exactly two cycles later with its own valid flag.

Top module: `lpf_wide_smooth`

## Requirements
- R1: `out_valid` equals `in_valid` from two clock cycles earlier, and a line can be accepted on every cycle.
- R2: In medium mode (`in_wide` = 0) with `in_mask8` = 1, each position i from 5 to 10 is replaced.
  - The new value is (x[i] + 4 + the sum over k = i-3..i+3 of x[clamp(k,4,11)]) >> 3.
  - Positions 0..4 and 11..15 are unchanged.
- R3: In wide mode (`in_wide` = 1) with `in_mask16` = 1, each position i from 1 to 14 is replaced.
  - The new value is (x[i] + 8 + the sum over k = i-7..i+7 of x[clamp(k,0,15)]) >> 4.
- R4: In wide mode with `in_mask16` = 0 and `in_mask8` = 1, the medium result of R2 is produced.
- R5: In medium mode, `in_mask16` has no effect on the output.
- R6: With both masks clear, `out_pix` equals `in_pix` in either mode.
- R7: In wide mode with both masks set, the wide result of R3 is produced and the medium result is not.
- R8: Positions 0 and 15 of `out_pix` always equal the corresponding input samples.
- R9: While `rst_n` is low, `out_valid` is 0 from the next clock edge on.
- R10: All-maximum and all-zero lines come out unchanged in both modes, with no wrap of the running sum.
- R11: Position i occupies bits [PIX_W*(i+1)-1 : PIX_W*i] of both pixel buses.
  - Position 0 is the far sample on the left side of the edge, position 7 is adjacent to the edge on the left, position 8 is adjacent on the right, and position 15 is the far sample on the right.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input line is valid |
| in_wide | input | 1 | 1 selects wide mode, 0 selects medium mode |
| in_mask8 | input | 1 | Medium smoothing enable for this line |
| in_mask16 | input | 1 | Wide smoothing enable for this line (wide mode only) |
| in_pix | input | 16*PIX_W | Sixteen input samples, packed as in R11 |
| out_valid | output | 1 | Output line is valid |
| out_pix | output | 16*PIX_W | Sixteen output samples, packed as in R11 |

## Verification
Every result of this block is due exactly two clock edges after its line is presented: one edge for the input register and one for the output register. The bench drives each line on a falling edge and pushes the line's behaviourally computed expectation into a queue that is kept two entries deep. On every later falling edge it pops the entry for the line driven two cycles before and compares `out_valid` and the whole sixteen-sample bus against it. Idle cycles are interleaved with lines so that the valid flag is checked in both states at its due cycle.

// File: rtl/lpf_pkg.sv
package lpf_pkg;
   localparam int LINE_PIX  = 16;
   localparam int MED_HALF  = 3;
   localparam int WIDE_HALF = 7;
   localparam int MED_N     = 2 * MED_HALF + 2;
   localparam int MED_LO    = LINE_PIX / 2 - MED_HALF - 1;
   localparam int LATENCY   = 2;

   function automatic int lo_idx(input int j, input int half);
      return (j - half < 0) ? 0 : j - half;
   endfunction

   function automatic int hi_idx(input int j, input int half, input int n);
      return (j + 1 + half > n - 1) ? n - 1 : j + 1 + half;
   endfunction
endpackage

// File: rtl/lpf_run_sum.sv
module lpf_run_sum #(
   parameter int PIX_W = 10,
   parameter int HALF  = 3
) (
   input  logic [(2*HALF+2)*PIX_W-1:0] win,
   output logic [(2*HALF+2)*PIX_W-1:0] filt
);
   import lpf_pkg::*;
   localparam int N     = 2 * HALF + 2;
   localparam int SHIFT = $clog2(N);
   // largest total is N*(2^PIX_W-1) + N/2, which is below 2^(PIX_W+SHIFT)
   localparam int SUM_W = PIX_W + SHIFT;
   localparam int ROUND = 1 << (SHIFT - 1);

   if (HALF < 1 || (1 << SHIFT) != N) begin : g_bad_half
      $error("lpf_run_sum: HALF must make 2*HALF+2 a power of two");
   end

   logic [PIX_W-1:0] px [N];
   logic [SUM_W-1:0] acc [1:N-2];
   logic [SUM_W-1:0] seed;

   for (genvar i = 0; i < N; i++) begin : g_unpack
      assign px[i] = win[i*PIX_W +: PIX_W];
   end

   // seed: far sample times HALF, first tap doubled, the rest once
   always_comb begin
      seed = SUM_W'(ROUND) + SUM_W'(HALF) * SUM_W'(px[0]) + (SUM_W'(px[1]) << 1);
      for (int k = 2; k <= HALF + 1; k++) begin
         seed = seed + SUM_W'(px[k]);
      end
   end

   assign acc[1] = seed;

   // each step removes the old centre and the sample leaving the window,
   // then adds the new centre and the sample entering it (originals only)
   for (genvar j = 1; j < N - 2; j++) begin : g_step
      localparam int LO = lo_idx(j, HALF);
      localparam int HI = hi_idx(j, HALF, N);
      assign acc[j+1] = acc[j] - SUM_W'(px[j]) - SUM_W'(px[LO])
                      + SUM_W'(px[j+1]) + SUM_W'(px[HI]);
   end

   assign filt[0 +: PIX_W]         = px[0];
   assign filt[(N-1)*PIX_W +: PIX_W] = px[N-1];
   for (genvar j = 1; j < N - 1; j++) begin : g_out
      assign filt[j*PIX_W +: PIX_W] = PIX_W'(acc[j] >> SHIFT);
   end
endmodule

// File: rtl/lpf_blend.sv
module lpf_blend #(
   parameter int PIX_W = 10,
   parameter int N     = 8
) (
   input  logic [N*PIX_W-1:0] old_line,
   input  logic [N*PIX_W-1:0] new_line,
   input  logic               sel,
   output logic [N*PIX_W-1:0] res
);
   // delta form: old + (sel ? new - old : 0), modulo PIX_W
   for (genvar i = 0; i < N; i++) begin : g_pix
      logic [PIX_W-1:0] delta;
      assign delta = new_line[i*PIX_W +: PIX_W] - old_line[i*PIX_W +: PIX_W];
      assign res[i*PIX_W +: PIX_W] = old_line[i*PIX_W +: PIX_W] + (delta & {PIX_W{sel}});
   end
endmodule

// File: rtl/lpf_wide_smooth.sv
module lpf_wide_smooth #(
   parameter int PIX_W    = 10,
   parameter bit HAS_WIDE = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_valid,
   input  logic                  in_wide,
   input  logic                  in_mask8,
   input  logic                  in_mask16,
   input  logic [16*PIX_W-1:0]   in_pix,
   output logic                  out_valid,
   output logic [16*PIX_W-1:0]   out_pix
);
   import lpf_pkg::*;
   localparam int LINE_W = LINE_PIX * PIX_W;
   localparam int MED_W  = MED_N * PIX_W;

   if (PIX_W < 8 || PIX_W > 14) begin : g_bad_width
      $error("lpf_wide_smooth: PIX_W must lie in 8..14");
   end

   // stage A: capture line and resolve which smoother owns it
   logic              a_valid;
   logic              a_wide_sel;
   logic              a_med_sel;
   logic [LINE_W-1:0] a_pix;
   logic              wide_hit;

   assign wide_hit = HAS_WIDE & in_wide & in_mask16;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a_valid    <= 1'b0;
         a_wide_sel <= 1'b0;
         a_med_sel  <= 1'b0;
         a_pix      <= '0;
      end else begin
         a_valid    <= in_valid;
         a_wide_sel <= wide_hit;
         a_med_sel  <= in_mask8 & ~wide_hit;
         a_pix      <= in_pix;
      end
   end

   // medium smoother on the eight samples around the edge
   logic [MED_W-1:0]  med_filt;
   logic [MED_W-1:0]  med_mix;
   logic [LINE_W-1:0] med_line;
   logic [LINE_W-1:0] line_res;

   lpf_run_sum #(.PIX_W(PIX_W), .HALF(MED_HALF)) u_med (
      .win  (a_pix[MED_LO*PIX_W +: MED_W]),
      .filt (med_filt)
   );

   lpf_blend #(.PIX_W(PIX_W), .N(MED_N)) u_med_mix (
      .old_line (a_pix[MED_LO*PIX_W +: MED_W]),
      .new_line (med_filt),
      .sel      (a_med_sel),
      .res      (med_mix)
   );

   always_comb begin
      med_line = a_pix;
      med_line[MED_LO*PIX_W +: MED_W] = med_mix;
   end

   // wide smoother variant
   if (HAS_WIDE) begin : g_wide
      logic [LINE_W-1:0] wide_filt;
      lpf_run_sum #(.PIX_W(PIX_W), .HALF(WIDE_HALF)) u_wide (
         .win  (a_pix),
         .filt (wide_filt)
      );
      lpf_blend #(.PIX_W(PIX_W), .N(LINE_PIX)) u_wide_mix (
         .old_line (med_line),
         .new_line (wide_filt),
         .sel      (a_wide_sel),
         .res      (line_res)
      );
   end else begin : g_no_wide
      assign line_res = med_line;
   end

   // stage B: output register
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_pix   <= '0;
      end else begin
         out_valid <= a_valid;
         out_pix   <= line_res;
      end
   end
endmodule

// File: rtl/lpf_wide_smooth_chk.sv
module lpf_wide_smooth_chk #(
   parameter int PIX_W = 10
) (
   input logic                clk,
   input logic                rst_n,
   input logic                in_valid,
   input logic                in_wide,
   input logic                in_mask8,
   input logic                in_mask16,
   input logic [16*PIX_W-1:0] in_pix,
   input logic                out_valid,
   input logic [16*PIX_W-1:0] out_pix
);
   logic [1:0] age;
   logic       warm;

   always_ff @(posedge clk) begin
      if (!rst_n)          age <= 2'd0;
      else if (age != 2'd2) age <= age + 2'd1;
   end
   assign warm = (age == 2'd2);

   AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
      warm |-> out_valid == $past(in_valid, 2)); // R1

   AST_OUTER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && out_valid) |-> (out_pix[PIX_W-1:0] == $past(in_pix[PIX_W-1:0], 2)
         && out_pix[16*PIX_W-1:15*PIX_W] == $past(in_pix[16*PIX_W-1:15*PIX_W], 2))); // R8

   AST_NO_MASK_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && out_valid && $past(!in_mask8 && !in_mask16, 2)) |-> out_pix == $past(in_pix, 2)); // R6

   AST_MED_REACH: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && out_valid && $past(!in_wide, 2)) |->
         (out_pix[5*PIX_W-1:0] == $past(in_pix[5*PIX_W-1:0], 2)
          && out_pix[16*PIX_W-1:11*PIX_W] == $past(in_pix[16*PIX_W-1:11*PIX_W], 2))); // R2

   AST_RESET_IDLE: assert property (@(posedge clk)
      !rst_n |=> !out_valid); // R9
endmodule

bind lpf_wide_smooth lpf_wide_smooth_chk #(.PIX_W(PIX_W)) u_chk (.*);

// File: tb/tb_lpf_wide_smooth.sv
`timescale 1ns/1ps
module tb_lpf_wide_smooth;
   localparam int W  = 10;
   localparam int LW = 16 * W;
   localparam int MAXV = (1 << W) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic          in_wide = 1'b0;
   logic          in_mask8 = 1'b0;
   logic          in_mask16 = 1'b0;
   logic [LW-1:0] in_pix = '0;
   logic          out_valid;
   logic [LW-1:0] out_pix;

   int checks = 0;
   int errors = 0;

   bit            qv [$];
   logic [LW-1:0] qp [$];
   string         qt [$];

   always #4 clk = ~clk;

   lpf_wide_smooth #(.PIX_W(W)) dut (
      .clk, .rst_n, .in_valid, .in_wide, .in_mask8, .in_mask16,
      .in_pix, .out_valid, .out_pix
   );

   function automatic int clampi(int k, int lo, int hi);
      return (k < lo) ? lo : ((k > hi) ? hi : k);
   endfunction

   // direct window form, computed independently of the running sum
   function automatic logic [LW-1:0] ref_line(logic [LW-1:0] v, bit wide, bit m8, bit m16);
      int px [16];
      int o [16];
      logic [LW-1:0] r;
      for (int i = 0; i < 16; i++) begin
         px[i] = int'(v[i*W +: W]);
         o[i]  = px[i];
      end
      if (wide && m16) begin
         for (int i = 1; i <= 14; i++) begin
            int s = px[i] + 8;
            for (int k = i - 7; k <= i + 7; k++) s += px[clampi(k, 0, 15)];
            o[i] = s >> 4;
         end
      end else if (m8) begin
         for (int i = 5; i <= 10; i++) begin
            int s = px[i] + 4;
            for (int k = i - 3; k <= i + 3; k++) s += px[clampi(k, 4, 11)];
            o[i] = s >> 3;
         end
      end
      for (int i = 0; i < 16; i++) r[i*W +: W] = W'(o[i]);
      return r;
   endfunction

   task automatic compare_front();
      bit            ev = qv.pop_front();
      logic [LW-1:0] ep = qp.pop_front();
      string         tg = qt.pop_front();
      checks++;
      if (ev) begin
         if (out_valid !== 1'b1 || out_pix !== ep) begin
            errors++;
            $display("FAIL %s: valid=%b pix=%h expected valid=1 pix=%h", tg, out_valid, out_pix, ep);
         end
      end else if (out_valid !== 1'b0) begin
         errors++;
         $display("FAIL %s: valid=%b expected 0", tg, out_valid);
      end
   endtask

   task automatic step(bit v, logic [LW-1:0] p, bit wide, bit m8, bit m16, string tg);
      @(negedge clk);
      compare_front();
      in_valid = v; in_pix = p; in_wide = wide; in_mask8 = m8; in_mask16 = m16;
      qv.push_back(v);
      qp.push_back(ref_line(p, wide, m8, m16));
      qt.push_back(tg);
   endtask

   function automatic logic [LW-1:0] rnd_line(int spread);
      logic [LW-1:0] r;
      int base = $urandom_range(0, MAXV);
      for (int i = 0; i < 16; i++) begin
         int x = base + $urandom_range(0, 2 * spread) - spread;
         r[i*W +: W] = W'(clampi(x, 0, MAXV));
      end
      return r;
   endfunction

   function automatic logic [LW-1:0] fill(int a, int b);
      logic [LW-1:0] r;
      for (int i = 0; i < 16; i++) r[i*W +: W] = W'((i < 8) ? a : b);
      return r;
   endfunction

   function automatic logic [LW-1:0] ramp();
      logic [LW-1:0] r;
      for (int i = 0; i < 16; i++) r[i*W +: W] = W'(i * 40 + 7);
      return r;
   endfunction

   initial begin
      #(200000 * 8);
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      checks++;
      if (out_valid !== 1'b0) begin
         errors++;
         $display("FAIL R9: valid=%b expected 0", out_valid);
      end
      rst_n = 1'b1;
      repeat (2) begin
         qv.push_back(1'b0); qp.push_back('0); qt.push_back("R9 after reset");
      end

      // R11: ramp exposes lane order in both modes
      step(1, ramp(), 0, 1, 0, "R11 medium ramp");
      step(1, ramp(), 1, 0, 1, "R11 wide ramp");
      // R6: both masks clear
      for (int i = 0; i < 6; i++) step(1, rnd_line(300), i[0], 0, 0, "R6 pass");
      // R2: medium smoothing, back to back
      for (int i = 0; i < 20; i++) step(1, rnd_line(60), 0, 1, 0, "R2 medium");
      step(1, fill(100, 900), 0, 1, 0, "R2 step edge");
      // R5: mask16 ignored in medium mode
      for (int i = 0; i < 6; i++) step(1, rnd_line(80), 0, i[0], 1, "R5 mask16 ignored");
      // R3: wide smoothing, with gaps for R1
      for (int i = 0; i < 20; i++) begin
         step(1, rnd_line(40), 1, 0, 1, "R3 wide");
         if (i % 4 == 0) step(0, rnd_line(500), 1, 1, 1, "R1 idle gap");
      end
      step(1, fill(900, 100), 1, 0, 1, "R3 step edge");
      // R4: wide mode falls back to medium
      for (int i = 0; i < 6; i++) step(1, rnd_line(70), 1, 1, 0, "R4 fallback");
      // R7: wide wins when both set
      for (int i = 0; i < 6; i++) step(1, rnd_line(70), 1, 1, 1, "R7 priority");
      // R10: extremes
      step(1, fill(MAXV, MAXV), 1, 1, 1, "R10 max wide");
      step(1, fill(MAXV, MAXV), 0, 1, 0, "R10 max medium");
      step(1, fill(0, 0), 1, 1, 1, "R10 zero wide");
      step(1, fill(0, MAXV), 1, 0, 1, "R10 full step");
      // R8: far samples on strongly varying lines
      for (int i = 0; i < 6; i++) step(1, rnd_line(MAXV), i[0], 1, 1, "R8 outer kept");
      // R1: alternating valid
      for (int i = 0; i < 8; i++) step(i[0], rnd_line(50), 1, 1, 1, "R1 toggle");
      repeat (2) step(0, '0, 0, 0, 0, "R1 drain");
      @(negedge clk);
      compare_front();
      @(negedge clk);
      compare_front();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule